// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Target

This block is the responding side of a shared synchronous bus on which one set of 32 wires carries first an address and then data. The four active-low control wires beside them carry a command code in the opening clock of a transaction and byte enables in every later clock. When the opening clock names an address inside the target's window together with a read or write command, the target claims the transaction and serves it from a small internal array of 32-bit words.

Data moves under a two-sided ready handshake. The initiator can stretch any data phase with wait states. The target answers without wait states and follows the address upward through a burst. When the next word would fall past the top of its window, it asks the initiator to end the burst. Even parity covers the 32 data wires plus the four control wires and runs one clock behind the data. The target drives parity for words it returns and checks parity for words it receives. A mismatch produces a one-clock error flag.

The window starts at `BASE_ADDR` and holds `WORDS` words, with `WORDS` a power of two. `BASE_ADDR` must be aligned to the window size.

Top module: `mux_bus_target`

## Requirements
- R1: While reset is high and in the first clock after it, devsel_n, trdy_n, stop_n and perr_n are high and ad_oe and par_oe are low.
- R2: In the clock after frame_n is first seen low, the target inspects ad_in and cbe_n. If the address lies in the window and cbe_n is 4'b0110 (read) or 4'b0111 (write), devsel_n and trdy_n go low in the next clock and remain low until the transaction ends.
- R3: An address outside the window, or any other command code, is never claimed. devsel_n stays high for the whole transaction and the stored words do not change.
- R4: A word moves only at a clock edge where both irdy_n and trdy_n are low. A clock with irdy_n high neither writes nor advances the address.
- R5: During a write data phase, cbe_n bit i low writes byte i (bits 8i+7..8i). The value 4'b0000 writes all four bytes. The value 4'b1111 writes nothing but still consumes the data phase and advances the address.
- R6: Each completed data phase advances the word address by one, which is 4 bytes.
- R7: stop_n is low exactly during data phases whose word is the last word of the window. After that word moves, the target releases devsel_n whether or not frame_n was still low, and ignores the bus until frame_n and irdy_n are both high.
- R8: A word that moves while frame_n is high is the final one. devsel_n and trdy_n are high in the next clock.
- R9: In the clock after a read word moves, par_oe is high and par_out makes the count of ones across that word, its cbe_n and par_out even. par_oe is low in every other clock.
- R10: The initiator presents write parity on par_in in the clock after a write word moves. If that parity breaks even parity over the word and its cbe_n, perr_n is low for the single following clock. Otherwise perr_n stays high.
- R11: During read data phases ad_oe is high and ad_out holds the stored word at the current address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all activity on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| frame_n | input | 1 | Low from the address clock until the final data phase begins |
| irdy_n | input | 1 | Initiator ready, active low |
| ad_in | input | 32 | Address in the first clock, write data afterwards |
| cbe_n | input | 4 | Command in the first clock, active-low byte enables afterwards |
| par_in | input | 1 | Even parity for ad_in/cbe_n of the previous clock |
| ad_out | output | 32 | Read data |
| ad_oe | output | 1 | High while the target drives read data |
| par_out | output | 1 | Even parity for the previous read word |
| par_oe | output | 1 | High while par_out is valid |
| devsel_n | output | 1 | Claim indicator, active low |
| trdy_n | output | 1 | Target ready, active low |
| stop_n | output | 1 | Request to end the burst, active low |
| perr_n | output | 1 | Write parity error, active low, one clock |

## Verification
A corrupted word index shows up at the very next read data phase, as a wrong word on ad_out or a stop_n at the wrong position in the burst. If the state machine fails to return to idle, devsel_n is still low in the clock after the final word, or the next transaction goes unclaimed. A slip in the parity pipeline by one stage moves par_oe or perr_n to the wrong clock relative to the transfer that caused it, so it shows within two clocks. A write applied under the wrong byte enables only becomes visible when the word is read back later, so the bench reads every written range again.

// File: rtl/mbt_pkg.sv
package mbt_pkg;

    localparam int AD_W = 32;
    localparam int BE_W = 4;

    localparam logic [BE_W-1:0] CMD_READ  = 4'b0110;
    localparam logic [BE_W-1:0] CMD_WRITE = 4'b0111;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DATA  = 2'd1,
        ST_DRAIN = 2'd2
    } tgt_state_e;

    typedef struct packed {
        logic hit;
        logic rd;
    } claim_t;

    function automatic logic even_par(input logic [AD_W-1:0] ad, input logic [BE_W-1:0] cbe);
        return ^{ad, cbe};
    endfunction

    function automatic logic [AD_W-1:0] merge_bytes(input logic [AD_W-1:0] old_w,
                                                    input logic [AD_W-1:0] new_w,
                                                    input logic [BE_W-1:0] be_n);
        logic [AD_W-1:0] res;
        res = old_w;
        for (int b = 0; b < BE_W; b++) begin
            if (!be_n[b]) res[8*b +: 8] = new_w[8*b +: 8];
        end
        return res;
    endfunction

endpackage

// File: rtl/mbt_decode.sv
module mbt_decode
    import mbt_pkg::*;
#(
    parameter logic [AD_W-1:0] BASE_ADDR = 32'h0000_1000,
    parameter int              WORDS     = 8,
    localparam int             IDXW      = $clog2(WORDS),
    localparam int             LOW       = IDXW + 2
) (
    input  logic [AD_W-1:2] word_addr,
    input  logic [BE_W-1:0] cmd,
    output claim_t          claim,
    output logic [IDXW-1:0] start_idx
);
    logic in_win;

    assign in_win          = (word_addr[AD_W-1:LOW] == BASE_ADDR[AD_W-1:LOW]);
    assign claim.rd        = (cmd == CMD_READ);
    assign claim.hit       = in_win && ((cmd == CMD_READ) || (cmd == CMD_WRITE));
    assign start_idx       = word_addr[LOW-1:2];
endmodule

// File: rtl/mbt_regfile.sv
module mbt_regfile
    import mbt_pkg::*;
#(
    parameter int  WORDS = 8,
    localparam int IDXW  = $clog2(WORDS)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            we,
    input  logic [IDXW-1:0] idx,
    input  logic [AD_W-1:0] wdata,
    input  logic [BE_W-1:0] be_n,
    output logic [AD_W-1:0] rdata
);
    logic [AD_W-1:0]  mem [WORDS];
    logic [WORDS-1:0] wsel;

    for (genvar w = 0; w < WORDS; w++) begin : g_sel
        assign wsel[w] = we && (idx == IDXW'(w));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int w = 0; w < WORDS; w++) mem[w] <= '0;
        end else begin
            for (int w = 0; w < WORDS; w++) begin
                if (wsel[w]) mem[w] <= merge_bytes(mem[w], wdata, be_n);
            end
        end
    end

    assign rdata = mem[idx];
endmodule

// File: rtl/mbt_parity.sv
module mbt_parity
    import mbt_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            rd_xfer,
    input  logic            wr_xfer,
    input  logic [AD_W-1:0] rd_word,
    input  logic [AD_W-1:0] wr_word,
    input  logic [BE_W-1:0] cbe_n,
    input  logic            par_in,
    output logic            par_out,
    output logic            par_oe,
    output logic            perr_n
);
    logic rd_pend, rd_par;
    logic wr_pend, wr_par;
    logic err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_pend <= 1'b0;
            rd_par  <= 1'b0;
            wr_pend <= 1'b0;
            wr_par  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            rd_pend <= rd_xfer;
            rd_par  <= even_par(rd_word, cbe_n);
            wr_pend <= wr_xfer;
            wr_par  <= even_par(wr_word, cbe_n);
            err_q   <= wr_pend && (par_in != wr_par);
        end
    end

    assign par_oe  = rd_pend;
    assign par_out = rd_par;
    assign perr_n  = !err_q;
endmodule

// File: rtl/mux_bus_target.sv
module mux_bus_target
    import mbt_pkg::*;
#(
    parameter logic [AD_W-1:0] BASE_ADDR = 32'h0000_1000,
    parameter int              WORDS     = 8,
    localparam int             IDXW      = $clog2(WORDS),
    localparam logic [IDXW-1:0] LAST     = IDXW'(WORDS - 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            frame_n,
    input  logic            irdy_n,
    input  logic [AD_W-1:0] ad_in,
    input  logic [BE_W-1:0] cbe_n,
    input  logic            par_in,
    output logic [AD_W-1:0] ad_out,
    output logic            ad_oe,
    output logic            par_out,
    output logic            par_oe,
    output logic            devsel_n,
    output logic            trdy_n,
    output logic            stop_n,
    output logic            perr_n
);
    tgt_state_e      state;
    logic [IDXW-1:0] idx;
    logic            is_rd;
    claim_t          claim;
    logic [IDXW-1:0] start_idx;
    logic [AD_W-1:0] rdata;
    logic            in_data, xfer;

    mbt_decode #(.BASE_ADDR(BASE_ADDR), .WORDS(WORDS)) u_dec (
        .word_addr (ad_in[AD_W-1:2]),
        .cmd       (cbe_n),
        .claim     (claim),
        .start_idx (start_idx)
    );

    assign in_data = (state == ST_DATA);
    assign xfer    = in_data && !irdy_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            idx   <= '0;
            is_rd <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: if (!frame_n) begin
                    idx   <= start_idx;
                    is_rd <= claim.rd;
                    state <= claim.hit ? ST_DATA : ST_DRAIN;
                end
                ST_DATA: if (xfer) begin
                    idx <= idx + 1'b1;
                    if (frame_n)          state <= ST_IDLE;
                    else if (idx == LAST) state <= ST_DRAIN;
                end
                ST_DRAIN: if (frame_n && irdy_n) state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    mbt_regfile #(.WORDS(WORDS)) u_rf (
        .clk   (clk),
        .rst   (rst),
        .we    (xfer && !is_rd),
        .idx   (idx),
        .wdata (ad_in),
        .be_n  (cbe_n),
        .rdata (rdata)
    );

    mbt_parity u_par (
        .clk     (clk),
        .rst     (rst),
        .rd_xfer (xfer && is_rd),
        .wr_xfer (xfer && !is_rd),
        .rd_word (ad_out),
        .wr_word (ad_in),
        .cbe_n   (cbe_n),
        .par_in  (par_in),
        .par_out (par_out),
        .par_oe  (par_oe),
        .perr_n  (perr_n)
    );

    assign devsel_n = !in_data;
    assign trdy_n   = !in_data;
    assign stop_n   = !(in_data && (idx == LAST));
    assign ad_oe    = in_data && is_rd;
    assign ad_out   = ad_oe ? rdata : '0;
endmodule

// File: rtl/mbt_checker.sv
module mbt_checker (
    input logic clk,
    input logic rst,
    input logic frame_n,
    input logic irdy_n,
    input logic ad_oe,
    input logic par_oe,
    input logic devsel_n,
    input logic trdy_n,
    input logic stop_n,
    input logic perr_n
);
    a_r2_claim_follows_frame: assert property (@(posedge clk) disable iff (rst)
        $fell(devsel_n) |-> $past(!frame_n));

    a_r2_ready_with_claim: assert property (@(posedge clk) disable iff (rst)
        trdy_n == devsel_n);

    a_r7_stop_inside_claim: assert property (@(posedge clk) disable iff (rst)
        !stop_n |-> !devsel_n);

    a_r7_release_after_stop: assert property (@(posedge clk) disable iff (rst)
        (!stop_n && !irdy_n) |=> devsel_n);

    a_r8_release_on_final: assert property (@(posedge clk) disable iff (rst)
        (!devsel_n && !irdy_n && frame_n) |=> devsel_n);

    a_r9_parity_after_read: assert property (@(posedge clk) disable iff (rst)
        par_oe |-> $past(ad_oe && !irdy_n && !trdy_n));

    a_r10_error_after_write: assert property (@(posedge clk) disable iff (rst)
        !perr_n |-> $past(!devsel_n && !ad_oe && !irdy_n, 2));

    a_r11_drive_when_claimed: assert property (@(posedge clk) disable iff (rst)
        ad_oe |-> !devsel_n);
endmodule

bind mux_bus_target mbt_checker u_mbt_checker (
    .clk      (clk),
    .rst      (rst),
    .frame_n  (frame_n),
    .irdy_n   (irdy_n),
    .ad_oe    (ad_oe),
    .par_oe   (par_oe),
    .devsel_n (devsel_n),
    .trdy_n   (trdy_n),
    .stop_n   (stop_n),
    .perr_n   (perr_n)
);

// File: tb/mux_bus_target_test.sv
module mux_bus_target_test;
    localparam int          PERIOD = 10;
    localparam int          NW     = 8;
    localparam logic [31:0] BASE   = 32'h0000_1000;
    localparam logic [3:0]  RD     = 4'b0110;
    localparam logic [3:0]  WR     = 4'b0111;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        frame_n = 1'b1, irdy_n = 1'b1, par_in = 1'b0;
    logic [31:0] ad_in = '0;
    logic [3:0]  cbe_n = '0;
    logic [31:0] ad_out;
    logic        ad_oe, par_out, par_oe, devsel_n, trdy_n, stop_n, perr_n;

    int checks = 0, fails = 0;
    logic [31:0] model [NW];
    logic [31:0] wd [NW];
    logic [3:0]  wb [NW];
    logic [31:0] expq [$];
    logic        pend = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    mux_bus_target #(.BASE_ADDR(BASE), .WORDS(NW)) uut (
        .clk(clk), .rst(rst), .frame_n(frame_n), .irdy_n(irdy_n), .ad_in(ad_in),
        .cbe_n(cbe_n), .par_in(par_in), .ad_out(ad_out), .ad_oe(ad_oe),
        .par_out(par_out), .par_oe(par_oe), .devsel_n(devsel_n), .trdy_n(trdy_n),
        .stop_n(stop_n), .perr_n(perr_n)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Monitor: read data scoreboard (R11), read parity (R9), write parity error (R10)
    logic rd1 = 1'b0, rdpar = 1'b0, wr1 = 1'b0, wrpar = 1'b0, wr2 = 1'b0, err2 = 1'b0;
    always @(negedge clk) begin
        if (rst) begin
            rd1 <= 1'b0; wr1 <= 1'b0; wr2 <= 1'b0;
        end else begin
            if (rd1) begin
                check("R9 par_oe", {31'd0, par_oe}, 32'd1);
                check("R9 par_out", {31'd0, par_out}, {31'd0, rdpar});
            end
            if (wr2) check("R10 perr_n", {31'd0, perr_n}, {31'd0, !err2});
            wr2  <= wr1;
            err2 <= wr1 && (par_in != wrpar);
            rd1  <= 1'b0;
            wr1  <= 1'b0;
            if (!devsel_n && !trdy_n && !irdy_n) begin
                if (ad_oe) begin
                    if (expq.size() == 0) begin
                        check("R11 unexpected read", 32'd1, 32'd0);
                    end else begin
                        check("R11 read word", ad_out, expq.pop_front());
                    end
                    rd1   <= 1'b1;
                    rdpar <= ^{ad_out, cbe_n};
                end else begin
                    wr1   <= 1'b1;
                    wrpar <= ^{ad_in, cbe_n};
                end
            end
        end
    end

    function automatic logic [31:0] apply_be(input logic [31:0] o, input logic [31:0] d, input logic [3:0] be);
        logic [31:0] r = o;
        for (int b = 0; b < 4; b++) if (!be[b]) r[8*b +: 8] = d[8*b +: 8];
        return r;
    endfunction

    // Driver: one transaction; pushes expected reads and updates the model
    task automatic xfer(input logic [3:0] cmd, input logic [31:0] addr, input int n,
                        input int ws_at, input int bad_at);
        logic hit;
        int   start, m;
        hit   = (addr[31:5] == BASE[31:5]) && (cmd == RD || cmd == WR);
        start = int'(addr[4:2]);
        m     = hit ? ((n < NW - start) ? n : NW - start) : n;
        @(posedge clk); #1;
        frame_n = 1'b0; irdy_n = 1'b1; ad_in = addr; cbe_n = cmd; par_in = pend;
        pend = ^{addr, cmd};
        for (int i = 0; i < m; i++) begin
            if (i == ws_at) begin
                @(posedge clk); #1;
                frame_n = 1'b0; irdy_n = 1'b1; ad_in = 32'hDEAD_BEEF; cbe_n = 4'b0000; par_in = pend;
                @(negedge clk);
                check("R4 ready held in wait", {31'd0, trdy_n}, {31'd0, !hit});
            end
            @(posedge clk); #1;
            frame_n = (i == n - 1); irdy_n = 1'b0;
            ad_in   = (cmd == WR) ? wd[i] : 32'd0;
            cbe_n   = (cmd == WR) ? wb[i] : 4'b0000;
            par_in  = pend;
            pend    = (^{ad_in, cbe_n}) ^ (i == bad_at);
            if (hit) begin
                if (cmd == WR) model[start+i] = apply_be(model[start+i], wd[i], wb[i]);
                else expq.push_back(model[start+i]);
            end
            @(negedge clk);
            check("R2/R3 claim", {31'd0, devsel_n}, {31'd0, !hit});
            if (hit) check("R7 stop position", {31'd0, stop_n}, {31'd0, !(start + i == NW - 1)});
        end
        @(posedge clk); #1;
        frame_n = 1'b1; irdy_n = 1'b1; ad_in = '0; cbe_n = '0; par_in = pend;
        @(negedge clk);
        check("R8 released", {31'd0, devsel_n}, 32'd1);
        @(posedge clk); #1;
    endtask

    task automatic set_w(input int i, input logic [31:0] d, input logic [3:0] be);
        wd[i] = d; wb[i] = be;
    endtask

    initial begin
        #(PERIOD * 100000);
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < NW; i++) begin model[i] = '0; wd[i] = '0; wb[i] = '0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check("R1 devsel_n", {31'd0, devsel_n}, 32'd1);
        check("R1 trdy_n", {31'd0, trdy_n}, 32'd1);
        check("R1 stop_n", {31'd0, stop_n}, 32'd1);
        check("R1 perr_n", {31'd0, perr_n}, 32'd1);
        check("R1 ad_oe/par_oe", {30'd0, ad_oe, par_oe}, 32'd0);
        @(posedge clk); #1 rst = 1'b0;
        @(negedge clk);
        check("R1 after reset", {28'd0, devsel_n, trdy_n, stop_n, perr_n}, 32'hF);

        // R2 R6: four-word write burst, then read back with a wait state
        for (int i = 0; i < 4; i++) set_w(i, 32'h1111_1111 * (i + 1), 4'b0000);
        xfer(WR, BASE, 4, -1, -1);
        xfer(RD, BASE, 4, 2, -1);

        // R5: single byte, null phase, upper half
        set_w(0, 32'hAABB_CCDD, 4'b1110);
        set_w(1, 32'h5555_5555, 4'b1111);
        set_w(2, 32'h6666_6666, 4'b0011);
        xfer(WR, BASE + 32'h4, 3, -1, -1);
        xfer(RD, BASE + 32'h4, 3, -1, -1);

        // R4: write with an initiator wait state
        set_w(0, 32'h7777_7777, 4'b0000);
        set_w(1, 32'h8888_8888, 4'b0000);
        xfer(WR, BASE + 32'h10, 2, 1, -1);
        xfer(RD, BASE + 32'h10, 2, -1, -1);

        // R7: bursts cut at the top of the window
        for (int i = 0; i < 4; i++) set_w(i, 32'h9999_0000 + i, 4'b0000);
        xfer(WR, BASE + 32'h18, 4, -1, -1);
        xfer(RD, BASE + 32'h14, 4, -1, -1);
        xfer(RD, BASE + 32'h1C, 1, -1, -1);

        // R3: out of window, and unsupported command in window
        set_w(0, 32'hFFFF_FFFF, 4'b0000);
        set_w(1, 32'hEEEE_EEEE, 4'b0000);
        xfer(WR, 32'h0000_2000, 2, -1, -1);
        xfer(4'b0010, BASE, 1, -1, -1);
        xfer(RD, BASE, 8, -1, -1);

        // R10: corrupt parity on second word of a write
        set_w(0, 32'h0123_4567, 4'b0000);
        set_w(1, 32'h89AB_CDEF, 4'b0000);
        xfer(WR, BASE, 2, -1, 1);
        repeat (3) @(posedge clk);
        xfer(RD, BASE, 2, -1, -1);
        repeat (3) @(posedge clk);

        check("R11 all reads seen", expq.size(), 32'd0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule